// File: doc/BRIEF.md
# Host Event Interrupt Aggregator

This block keeps a vector of pending host events and three enable masks, one each for the system-management interrupt, the ACPI system-control interrupt and the wake line. A status update compares the masked sets and drives three active-low outputs toward the host chipset. The two interrupt outputs are edge-style pulses: high, then low, then high again. The wake output is a level. Two status flags show whether the SMI and SCI masked sets are currently non-empty.

Firmware writes the event vector and the masks over a small local bus that has a single valid strobe. A separate query strobe returns the number of the lowest pending event that some mask enables and clears it. Any pending event below it that no mask enables is discarded silently. A resume input clears every mask. No update takes effect until firmware has written the init-done flag.

Top module: `host_evt_aggr`

## Requirements
- R1: After reset, smiN, sciN and wakeN are 1, smiFlag and sciFlag are 0, and qryValid is 0.
- R2: The register map is as follows: address 0 holds the event vector, 1 the SMI mask, 2 the SCI mask and 3 the wake mask. A write to address 4 with data bit 0 set sets the init-done flag, and that write triggers an update. Before init-done is set, no write causes an update, so no pulse starts and the flags stay 0.
- R3: On an update, an SMI pulse starts only when (events AND SMI mask) is non-zero and smiFlag is 0. smiFlag then becomes 1, and it returns to 0 on the next update in which the masked set is zero.
- R4: Every update in which (events AND SCI mask) is non-zero starts an SCI pulse. On each update, sciFlag is set to whether that masked set is non-zero.
- R5: A pulse holds its line high for PULSE_CYC cycles, then low for exactly PULSE_CYC cycles, then releases it high.
- R6: A pulse request that arrives while a pulse is in progress is held, and a second pulse is issued once the current one ends.
- R7: After each update, wakeN is 0 if and only if (events AND wake mask) is non-zero once bit PWRBTN_BIT (default 1) has been removed from that term.
- R8: An event-vector write triggers an update only when its value differs from the current vector. A mask write always triggers an update.
- R9: A query scans the events from bit 0 upward. It clears every pending bit up to and including the first one that is set in at least one mask, and returns that bit's index plus one. If no pending bit is enabled, all pending bits are cleared and the query returns 0. The result appears on qryIndex with qryValid one cycle after qryReq. A query that changes the vector triggers an update.
- R10: resumeIn clears all three masks and triggers an update. It leaves the events in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWData | input | EVT_W | Write data |
| resumeIn | input | 1 | Clears all masks |
| qryReq | input | 1 | Query strobe |
| qryValid | output | 1 | Query result valid |
| qryIndex | output | IDX_W | Event number plus one, 0 if none |
| smiN | output | 1 | Active-low SMI pulse |
| sciN | output | 1 | Active-low SCI pulse |
| wakeN | output | 1 | Active-low wake level |
| smiFlag | output | 1 | SMI status flag |
| sciFlag | output | 1 | SCI status flag |

## Verification
The bench builds the block with PULSE_CYC at 4 and keeps the default 32-bit event width and power-button bit 1. With pulses of only eight cycles, the bench can count every pulse across a long run of updates and measure each low phase exactly. The same short pulses let it reach the held-request case by issuing two mask writes inside a single pulse. The 32-bit width keeps query scans that skip several disabled low bits before reaching an enabled one.

// File: rtl/hea_pkg.sv
package hea_pkg;
  localparam logic [2:0] A_EVENTS = 3'd0;
  localparam logic [2:0] A_SMI    = 3'd1;
  localparam logic [2:0] A_SCI    = 3'd2;
  localparam logic [2:0] A_WAKE   = 3'd3;
  localparam logic [2:0] A_INIT   = 3'd4;

  typedef struct packed {
    logic evtWr;
    logic smiWr;
    logic sciWr;
    logic wakeWr;
    logic initWr;
    logic clrMasks;
    logic qry;
  } strobe_t;
endpackage

// File: rtl/hea_pulse.sv
module hea_pulse #(
  parameter int unsigned CYC = 8125
) (
  input  logic clk,
  input  logic rstN,
  input  logic req,
  output logic lineN
);
  localparam int unsigned CNT_W = (CYC > 1) ? $clog2(CYC + 1) : 1;

  typedef enum logic [1:0] {P_IDLE, P_HIGH, P_LOW} pst_t;
  pst_t state;
  logic [CNT_W-1:0] cnt;
  logic pend;
  logic last;

  assign last  = (cnt == CNT_W'(CYC - 1));
  assign lineN = (state != P_LOW);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= P_IDLE;
      cnt   <= '0;
      pend  <= 1'b0;
    end else begin
      case (state)
        P_IDLE: if (req) begin
          state <= P_HIGH;
          cnt   <= '0;
        end
        P_HIGH: begin
          if (req) pend <= 1'b1;
          if (last) begin
            state <= P_LOW;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (last) begin
            cnt <= '0;
            if (pend || req) begin
              state <= P_HIGH;
              pend  <= 1'b0;
            end else state <= P_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            if (req) pend <= 1'b1;
          end
        end
      endcase
    end
  end

  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (req && state == P_HIGH) |=> pend);

  generate
    if (CYC > 1) begin : g_lowChk
      // R5
      low_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        $fell(lineN) |=> !lineN);
    end
  endgenerate
endmodule

// File: rtl/hea_dp.sv
module hea_dp
  import hea_pkg::*;
#(
  parameter int unsigned EVT_W      = 32,
  parameter int unsigned PWRBTN_BIT = 1,
  localparam int unsigned IDX_W     = $clog2(EVT_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [EVT_W-1:0] wdata,
  output logic             initDone,
  output logic             evtChg,
  output logic             smiAny,
  output logic             sciAny,
  output logic             wakeAny,
  output logic             qryValid,
  output logic [IDX_W-1:0] qryIndex
);
  localparam logic [EVT_W-1:0] PB_MASK = EVT_W'(1) << PWRBTN_BIT;

  logic [EVT_W-1:0] events, smiMask, sciMask, wakeMask;
  logic [EVT_W-1:0] pend, keepMask, qryNext, evtNext;
  logic             hit;
  logic [IDX_W-1:0] hitIdx;

  always_comb begin
    pend   = events & (smiMask | sciMask | wakeMask);
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = EVT_W - 1; i >= 0; i--) begin
      if (pend[i]) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
    for (int i = 0; i < EVT_W; i++) keepMask[i] = hit && (IDX_W'(i) > hitIdx);
    qryNext = events & keepMask;
    if (stb.evtWr)    evtNext = wdata;
    else if (stb.qry) evtNext = qryNext;
    else              evtNext = events;
  end

  assign evtChg  = (evtNext != events);
  assign smiAny  = |(events & smiMask);
  assign sciAny  = |(events & sciMask);
  assign wakeAny = |(events & wakeMask & ~PB_MASK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      events   <= '0;
      smiMask  <= '0;
      sciMask  <= '0;
      wakeMask <= '0;
      initDone <= 1'b0;
      qryValid <= 1'b0;
      qryIndex <= '0;
    end else begin
      events <= evtNext;
      if (stb.clrMasks) begin
        smiMask  <= '0;
        sciMask  <= '0;
        wakeMask <= '0;
      end else begin
        if (stb.smiWr)  smiMask  <= wdata;
        if (stb.sciWr)  sciMask  <= wdata;
        if (stb.wakeWr) wakeMask <= wdata;
      end
      if (stb.initWr) initDone <= 1'b1;
      qryValid <= stb.qry;
      qryIndex <= hit ? hitIdx + IDX_W'(1) : '0;
    end
  end

  // R10
  resume_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrMasks |=> (smiMask == '0 && sciMask == '0 && wakeMask == '0));

  // R9
  qry_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.qry |=> qryValid);

  // R9
  qry_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    qryValid |-> (qryIndex <= IDX_W'(EVT_W)));
endmodule

// File: rtl/hea_ctrl.sv
module hea_ctrl
  import hea_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 8125
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busValid,
  input  logic [2:0] busAddr,
  input  logic       initBit,
  input  logic       resumeIn,
  input  logic       qryReq,
  input  logic       initDone,
  input  logic       evtChg,
  input  logic       smiAny,
  input  logic       sciAny,
  input  logic       wakeAny,
  output strobe_t    stb,
  output logic       smiN,
  output logic       sciN,
  output logic       wakeN,
  output logic       smiFlag,
  output logic       sciFlag
);
  logic       updReq, updNow;
  logic [1:0] pReq, pLine;

  always_comb begin
    stb          = '0;
    stb.evtWr    = busValid && (busAddr == A_EVENTS);
    stb.smiWr    = busValid && (busAddr == A_SMI);
    stb.sciWr    = busValid && (busAddr == A_SCI);
    stb.wakeWr   = busValid && (busAddr == A_WAKE);
    stb.initWr   = busValid && (busAddr == A_INIT) && initBit;
    stb.clrMasks = resumeIn;
    stb.qry      = qryReq;
  end

  assign updReq = (initDone || stb.initWr) &&
                  (evtChg || stb.smiWr || stb.sciWr || stb.wakeWr ||
                   stb.clrMasks || stb.initWr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updNow  <= 1'b0;
      smiFlag <= 1'b0;
      sciFlag <= 1'b0;
      wakeN   <= 1'b1;
    end else begin
      updNow <= updReq;
      if (updNow) begin
        smiFlag <= smiAny;
        sciFlag <= sciAny;
        wakeN   <= !wakeAny;
      end
    end
  end

  assign pReq[0] = updNow && smiAny && !smiFlag;
  assign pReq[1] = updNow && sciAny;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_pulse
      hea_pulse #(.CYC(PULSE_CYC)) u_pulse (
        .clk  (clk),
        .rstN (rstN),
        .req  (pReq[g]),
        .lineN(pLine[g])
      );
    end
  endgenerate

  assign smiN = pLine[0];
  assign sciN = pLine[1];

  // R2
  no_upd_before_init_chk: assert property (@(posedge clk) disable iff (!rstN)
    updNow |-> initDone);

  // R3
  smi_flag_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(smiFlag) |-> $past(updNow));

  // R7
  wake_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wakeN) |-> $past(updNow && wakeAny));
endmodule

// File: rtl/host_evt_aggr.sv
module host_evt_aggr
  import hea_pkg::*;
#(
  parameter int unsigned EVT_W      = 32,
  parameter int unsigned PULSE_CYC  = 8125,
  parameter int unsigned PWRBTN_BIT = 1,
  localparam int unsigned IDX_W     = $clog2(EVT_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic [2:0]       busAddr,
  input  logic [EVT_W-1:0] busWData,
  input  logic             resumeIn,
  input  logic             qryReq,
  output logic             qryValid,
  output logic [IDX_W-1:0] qryIndex,
  output logic             smiN,
  output logic             sciN,
  output logic             wakeN,
  output logic             smiFlag,
  output logic             sciFlag
);
  strobe_t stb;
  logic initDone, evtChg, smiAny, sciAny, wakeAny;

  hea_ctrl #(.PULSE_CYC(PULSE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busAddr(busAddr),
    .initBit(busWData[0]), .resumeIn(resumeIn), .qryReq(qryReq),
    .initDone(initDone), .evtChg(evtChg), .smiAny(smiAny),
    .sciAny(sciAny), .wakeAny(wakeAny), .stb(stb), .smiN(smiN),
    .sciN(sciN), .wakeN(wakeN), .smiFlag(smiFlag), .sciFlag(sciFlag)
  );

  hea_dp #(.EVT_W(EVT_W), .PWRBTN_BIT(PWRBTN_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWData),
    .initDone(initDone), .evtChg(evtChg), .smiAny(smiAny),
    .sciAny(sciAny), .wakeAny(wakeAny), .qryValid(qryValid),
    .qryIndex(qryIndex)
  );
endmodule

// File: tb/host_evt_aggr_tb.sv
`timescale 1ns/1ps
module host_evt_aggr_tb;
  localparam int unsigned EVT_W = 32;
  localparam int unsigned PCYC  = 4;
  localparam int unsigned IDX_W = $clog2(EVT_W + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0;
  logic [2:0] busAddr = '0;
  logic [EVT_W-1:0] busWData = '0;
  logic resumeIn = 1'b0;
  logic qryReq = 1'b0;
  logic qryValid;
  logic [IDX_W-1:0] qryIndex;
  logic smiN, sciN, wakeN, smiFlag, sciFlag;

  int errors = 0;
  int checks = 0;
  int smiFalls = 0, sciFalls = 0;
  int smiRun = 0, sciRun = 0, smiLowLen = 0, sciLowLen = 0;
  logic prevSmi = 1'b1, prevSci = 1'b1;
  int expQ[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  host_evt_aggr #(.EVT_W(EVT_W), .PULSE_CYC(PCYC), .PWRBTN_BIT(1)) u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busAddr(busAddr),
    .busWData(busWData), .resumeIn(resumeIn), .qryReq(qryReq),
    .qryValid(qryValid), .qryIndex(qryIndex), .smiN(smiN), .sciN(sciN),
    .wakeN(wakeN), .smiFlag(smiFlag), .sciFlag(sciFlag)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic busWr(logic [2:0] a, logic [EVT_W-1:0] d);
    @(negedge clk);
    busValid = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic query(int exp);
    @(negedge clk);
    expQ.push_back(exp);
    qryReq = 1'b1;
    @(negedge clk);
    qryReq = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pulse counting, low-phase length and query scoreboard.
  always @(negedge clk) begin
    if (rstN) begin
      if (prevSmi && !smiN) smiFalls++;
      if (prevSci && !sciN) sciFalls++;
      if (!smiN) smiRun++; else if (!prevSmi) begin smiLowLen = smiRun; smiRun = 0; end
      if (!sciN) sciRun++; else if (!prevSci) begin sciLowLen = sciRun; sciRun = 0; end
      prevSmi = smiN;
      prevSci = sciN;
      if (qryValid) begin
        if (expQ.size() == 0) chk("R9 unexpected result", 1, 0);
        else chk("R9 query index", int'(qryIndex), expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 smiN", smiN, 1); chk("R1 sciN", sciN, 1); chk("R1 wakeN", wakeN, 1);
    chk("R1 smiFlag", smiFlag, 0); chk("R1 sciFlag", sciFlag, 0);
    chk("R1 qryValid", qryValid, 0);

    // R2 nothing before init
    busWr(3'd1, 32'h1); busWr(3'd0, 32'h1); idle(20);
    chk("R2 no pulse before init", smiFalls, 0);
    chk("R2 flag before init", smiFlag, 0);
    busWr(3'd4, 32'h1); idle(20);
    chk("R3 first smi pulse", smiFalls, 1);
    chk("R3 smiFlag set", smiFlag, 1);
    chk("R5 smi low length", smiLowLen, PCYC);

    // R3 second masked event: no new pulse while flag set
    busWr(3'd0, 32'h3); idle(20);
    chk("R3 no second smi pulse", smiFalls, 1);

    // R4 SCI
    busWr(3'd2, 32'h2); idle(20);
    chk("R4 sci pulse", sciFalls, 1);
    chk("R4 sciFlag", sciFlag, 1);
    chk("R5 sci low length", sciLowLen, PCYC);

    // R8 same value: no update; new value: update
    busWr(3'd0, 32'h3); idle(20);
    chk("R8 unchanged write no update", sciFalls, 1);
    busWr(3'd0, 32'h7); idle(20);
    chk("R8 changed write updates", sciFalls, 2);

    // R7 wake, power-button bit excluded
    busWr(3'd3, 32'h2); idle(20);
    chk("R7 pb bit excluded", wakeN, 1);
    chk("R8 mask write updates", sciFalls, 3);
    busWr(3'd3, 32'h6); idle(20);
    chk("R7 wake asserted", wakeN, 0);

    // R6 request during pulse is held
    busWr(3'd2, 32'h6); busWr(3'd2, 32'h2); idle(30);
    chk("R6 held request pulse", sciFalls, 6);

    // R3/R4/R7 clear
    busWr(3'd0, 32'h0); idle(20);
    chk("R3 smiFlag cleared", smiFlag, 0);
    chk("R4 sciFlag cleared", sciFlag, 0);
    chk("R7 wake released", wakeN, 1);
    chk("R4 no pulse when empty", sciFalls, 6);
    busWr(3'd0, 32'h1); idle(20);
    chk("R3 new first event pulses", smiFalls, 2);

    // R10 resume
    @(negedge clk); resumeIn = 1'b1; @(negedge clk); resumeIn = 1'b0;
    idle(5);
    chk("R10 smiFlag after resume", smiFlag, 0);
    query(0); idle(5); // R10 masks cleared: bit 0 dropped
    chk("R10 no pulse after resume", smiFalls, 2);

    // R9 scan/drop
    busWr(3'd1, 32'h10); busWr(3'd2, 32'h100); busWr(3'd0, 32'h135); idle(20);
    chk("R3 smi pulse on 0x135", smiFalls, 3);
    chk("R4 sci pulse on 0x135", sciFalls, 7);
    query(5); idle(20);
    chk("R9 query update sci", sciFalls, 8);
    chk("R9 query update smiFlag", smiFlag, 0);
    query(9); idle(5);
    query(0); idle(5);
    busWr(3'd0, 32'h3); idle(5);
    query(0); idle(5);
    query(0); idle(5);
    chk("R9 scoreboard drained", expQ.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule